// File: doc/BRIEF.md
# Processor Startup Interrupt Sequencer

This block is the per-processor control logic that decides when a processor is held after an INIT event, when it is released, and where it starts executing. It holds the interrupt-controller base register. Writes to that register may move its address field, and they may switch the global-enable flag off but never back on. The block also keeps the timer's initial count and load timestamp, which INIT clears.

A startup message latches an 8-bit vector and raises a pending request toward the processor. When the processor acknowledges the request, the request is consumed. If the processor had been armed by an INIT, it is released: a one-cycle start pulse is produced, along with a code-segment selector of vector<<8 and a segment base of vector<<12.

A startup message that arrives without a preceding INIT is consumed silently. The bootstrap processor, selected by a strap sampled at reset, is never halted by INIT. It is still armed, so its next startup message also produces a start pulse.

The control core is a three-state machine:
- `ST_RUN`: running and not armed.
- `ST_HELD`: halted and armed.
- `ST_ARMED`: running and armed (bootstrap processor after INIT).

Its transitions are:
- `init_ap`: any state goes to `ST_HELD` on INIT when the bootstrap flag is clear.
- `init_bsp`: any state goes to `ST_ARMED` on INIT when the bootstrap flag is set.
- `release`: `ST_HELD` or `ST_ARMED` goes to `ST_RUN` when an acknowledged startup request is consumed.
- `stay`: every other cycle keeps the current state.

All outputs are registered and change one clock after the input cycle that causes them.

Top module: `cpu_boot_sequencer`

## Requirements
- R1: After reset the base register reads 0x00000000_FEE00800 with bit 8 (bootstrap flag) equal to `bsp_strap`. `halted`, `sipi_pending` and `start_pulse` are 0, and `cs_sel`, `cs_base`, `tmr_count` and `tmr_stamp` are 0.
- R2: A base write sets bits 31:12 from `base_wr_data[31:12]` and keeps bit 8 from the current register. All other bits read 0, except bit 11 as given by R3.
- R3: Bit 11 (global enable) after a base write is the AND of its current value and `base_wr_data[11]`. Once it is clear, only reset sets it again.
- R4: On `init_evt`, the processor becomes halted if bit 8 is clear and stays running if bit 8 is set. In both cases the wait-for-startup flag is armed.
- R5: A timer write loads `tmr_count` and captures `now_stamp` into `tmr_stamp`. `init_evt` clears both to 0 and takes priority over a timer write in the same cycle.
- R6: `sipi_evt` latches `sipi_vec` and sets `sipi_pending`. Of several startup messages before an acknowledge, the last vector is used.
- R7: Suppose `sipi_ack` arrives while `sipi_pending` is set and the wait flag is armed. One cycle later `start_pulse` is high for exactly one cycle, `cs_sel` equals vector<<8 (16 bits), `cs_base` equals vector<<12 (32 bits), `halted` is 0, and both `sipi_pending` and the wait flag are cleared.
- R8: `sipi_ack` on a pending request while the wait flag is not armed clears `sipi_pending` only. No start pulse occurs, and `cs_sel`, `cs_base` and `halted` are unchanged.
- R9: `sipi_ack` with no pending request has no effect on any output.
- R10: `sipi_ack` in the same cycle as `init_evt` or `sipi_evt` is ignored, so the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsp_strap | input | 1 | Marks this processor as the bootstrap processor at reset |
| base_wr_en | input | 1 | Write strobe for the base register |
| base_wr_data | input | 64 | Value written to the base register |
| init_evt | input | 1 | INIT event, one cycle |
| sipi_evt | input | 1 | Startup message, one cycle |
| sipi_vec | input | 8 | Vector carried by the startup message |
| sipi_ack | input | 1 | Processor takes the pending startup request |
| tmr_wr_en | input | 1 | Write strobe for the timer initial count |
| tmr_wr_count | input | 32 | Timer initial count value |
| now_stamp | input | 64 | Current time, captured on a timer write |
| base_q | output | 64 | Base register contents |
| halted | output | 1 | Processor is held |
| sipi_pending | output | 1 | Startup request waiting for the processor |
| start_pulse | output | 1 | One-cycle release strobe |
| cs_sel | output | 16 | Code-segment selector to start from |
| cs_base | output | 32 | Code-segment base to start from |
| tmr_count | output | 32 | Timer initial count |
| tmr_stamp | output | 64 | Timestamp of the last timer load |

## Verification
The release path is driven in several ways:
- An application processor after INIT must release.
- A second startup message without INIT must be swallowed.
- An acknowledge with nothing pending must be inert.
- A bootstrap processor after INIT must release without ever being halted.

Back-to-back startup messages with vectors 0x01 then 0xFF show that the last vector is used and that the top vector bits shift correctly. An acknowledge in the same cycle as an INIT shows the priority rule. Base writes with bit 11 cleared and then set, and with bit 8 cleared on a bootstrap processor, show the difference between a sticky-clear flag and a preserved flag.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    localparam int BSP_BIT  = 8;
    localparam int EN_BIT   = 11;
    localparam int ADDR_LSB = 12;
    localparam int ADDR_MSB = 31;
    localparam int ADDR_W   = ADDR_MSB - ADDR_LSB + 1;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HELD  = 2'd1,
        ST_ARMED = 2'd2
    } boot_state_e;
endpackage

// File: rtl/cbs_base_reg.sv
module cbs_base_reg
    import cbs_pkg::*;
#(
    parameter int BASE_W = 64,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFEE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bsp_strap,
    input  logic              wr_en,
    input  logic [BASE_W-1:0] wr_data,
    output logic [BASE_W-1:0] base_q
);
    logic [BASE_W-1:0] reset_val;
    logic [BASE_W-1:0] next_val;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[BASE_W-1:ADDR_MSB+1], wr_data[EN_BIT-1:0]};

    always_comb begin
        reset_val                   = '0;
        reset_val[ADDR_MSB:ADDR_LSB] = RESET_ADDR;
        reset_val[EN_BIT]           = 1'b1;
        reset_val[BSP_BIT]          = bsp_strap;
    end

    always_comb begin
        next_val                    = '0;
        next_val[ADDR_MSB:ADDR_LSB] = wr_data[ADDR_MSB:ADDR_LSB];
        next_val[BSP_BIT]           = base_q[BSP_BIT];
        next_val[EN_BIT]            = base_q[EN_BIT] & wr_data[EN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= reset_val;
        end else if (wr_en) begin
            base_q <= next_val;
        end
    end
endmodule

// File: rtl/cbs_timer_ctx.sv
module cbs_timer_ctx #(
    parameter int CNT_W   = 32,
    parameter int STAMP_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_evt,
    input  logic               wr_en,
    input  logic [CNT_W-1:0]   wr_count,
    input  logic [STAMP_W-1:0] now_stamp,
    output logic [CNT_W-1:0]   count_q,
    output logic [STAMP_W-1:0] stamp_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            stamp_q <= '0;
        end else if (init_evt) begin
            count_q <= '0;
            stamp_q <= '0;
        end else if (wr_en) begin
            count_q <= wr_count;
            stamp_q <= now_stamp;
        end
    end
endmodule

// File: rtl/cbs_mailbox.sv
module cbs_mailbox #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_evt,
    input  logic             sipi_evt,
    input  logic [VEC_W-1:0] sipi_vec,
    input  logic             sipi_ack,
    output logic             pending_q,
    output logic [VEC_W-1:0] vec_q,
    output logic             take
);
    // An acknowledge is honoured only on a quiet cycle with a request waiting.
    assign take = sipi_ack & pending_q & ~init_evt & ~sipi_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            vec_q     <= '0;
        end else if (sipi_evt) begin
            pending_q <= 1'b1;
            vec_q     <= sipi_vec;
        end else if (take) begin
            pending_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cbs_fsm.sv
module cbs_fsm
    import cbs_pkg::*;
#(
    parameter int VEC_W      = 8,
    parameter int SEL_SHIFT  = 8,
    parameter int BASE_SHIFT = 12,
    parameter int SEL_W      = 16,
    parameter int CSB_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_evt,
    input  logic             is_bsp,
    input  logic             take,
    input  logic [VEC_W-1:0] vec_q,
    output logic             halted,
    output logic             start_pulse,
    output logic [SEL_W-1:0] cs_sel,
    output logic [CSB_W-1:0] cs_base
);
    boot_state_e state_q, state_d;
    logic        release_now;

    assign release_now = take & (state_q != ST_RUN);

    // next state
    always_comb begin
        state_d = state_q;
        if (init_evt) begin
            state_d = is_bsp ? ST_ARMED : ST_HELD;
        end else begin
            unique case (state_q)
                ST_RUN:   state_d = ST_RUN;
                ST_HELD:  state_d = take ? ST_RUN : ST_HELD;
                ST_ARMED: state_d = take ? ST_RUN : ST_ARMED;
                default:  state_d = ST_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    assign halted = (state_q == ST_HELD);

    // registered release outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            cs_sel      <= '0;
            cs_base     <= '0;
        end else begin
            start_pulse <= release_now;
            if (release_now) begin
                cs_sel  <= SEL_W'(vec_q) << SEL_SHIFT;
                cs_base <= CSB_W'(vec_q) << BASE_SHIFT;
            end
        end
    end
endmodule

// File: rtl/cpu_boot_sequencer.sv
module cpu_boot_sequencer
    import cbs_pkg::*;
#(
    parameter int BASE_W  = 64,
    parameter int VEC_W   = 8,
    parameter int CNT_W   = 32,
    parameter int STAMP_W = 64,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFEE00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bsp_strap,
    input  logic               base_wr_en,
    input  logic [BASE_W-1:0]  base_wr_data,
    input  logic               init_evt,
    input  logic               sipi_evt,
    input  logic [VEC_W-1:0]   sipi_vec,
    input  logic               sipi_ack,
    input  logic               tmr_wr_en,
    input  logic [CNT_W-1:0]   tmr_wr_count,
    input  logic [STAMP_W-1:0] now_stamp,
    output logic [BASE_W-1:0]  base_q,
    output logic               halted,
    output logic               sipi_pending,
    output logic               start_pulse,
    output logic [VEC_W+7:0]   cs_sel,
    output logic [VEC_W+23:0]  cs_base,
    output logic [CNT_W-1:0]   tmr_count,
    output logic [STAMP_W-1:0] tmr_stamp
);
    localparam int SEL_SHIFT  = 8;
    localparam int BASE_SHIFT = 12;
    localparam int SEL_W      = VEC_W + SEL_SHIFT;
    localparam int CSB_W      = VEC_W + 24;

    logic             take;
    logic [VEC_W-1:0] vec_q;

    cbs_base_reg #(.BASE_W(BASE_W), .RESET_ADDR(RESET_ADDR)) u_base (
        .clk(clk), .rst_n(rst_n), .bsp_strap(bsp_strap),
        .wr_en(base_wr_en), .wr_data(base_wr_data), .base_q(base_q)
    );

    cbs_timer_ctx #(.CNT_W(CNT_W), .STAMP_W(STAMP_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .init_evt(init_evt),
        .wr_en(tmr_wr_en), .wr_count(tmr_wr_count), .now_stamp(now_stamp),
        .count_q(tmr_count), .stamp_q(tmr_stamp)
    );

    cbs_mailbox #(.VEC_W(VEC_W)) u_mbox (
        .clk(clk), .rst_n(rst_n), .init_evt(init_evt),
        .sipi_evt(sipi_evt), .sipi_vec(sipi_vec), .sipi_ack(sipi_ack),
        .pending_q(sipi_pending), .vec_q(vec_q), .take(take)
    );

    cbs_fsm #(
        .VEC_W(VEC_W), .SEL_SHIFT(SEL_SHIFT), .BASE_SHIFT(BASE_SHIFT),
        .SEL_W(SEL_W), .CSB_W(CSB_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .init_evt(init_evt),
        .is_bsp(base_q[BSP_BIT]), .take(take), .vec_q(vec_q),
        .halted(halted), .start_pulse(start_pulse),
        .cs_sel(cs_sel), .cs_base(cs_base)
    );
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bsp_strap,
    input logic        base_wr_en,
    input logic [63:0] base_wr_data,
    input logic        init_evt,
    input logic        sipi_evt,
    input logic [7:0]  sipi_vec,
    input logic        sipi_ack,
    input logic        tmr_wr_en,
    input logic [31:0] tmr_wr_count,
    input logic [63:0] now_stamp,
    input logic [63:0] base_q,
    input logic        halted,
    input logic        sipi_pending,
    input logic        start_pulse,
    input logic [15:0] cs_sel,
    input logic [31:0] cs_base,
    input logic [31:0] tmr_count,
    input logic [63:0] tmr_stamp
);
    assert_base_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |=> base_q[31:12] == $past(base_wr_data[31:12]));

    assert_bsp_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |=> base_q[8] == $past(base_q[8]));

    assert_en_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(base_q[11]));

    assert_ap_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (init_evt && !base_q[8]) |=> halted);

    assert_bsp_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (init_evt && base_q[8]) |=> !halted);

    assert_tmr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        init_evt |=> (tmr_count == 32'd0 && tmr_stamp == 64'd0));

    assert_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sipi_evt |=> sipi_pending);

    assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (!halted && !sipi_pending && cs_base == {12'h000, cs_sel[15:8], 12'h000}));

    assert_pulse_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sipi_pending |=> !start_pulse);

    assert_init_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (init_evt && sipi_ack && sipi_pending) |=> sipi_pending);
endmodule

bind cpu_boot_sequencer cbs_checker u_chk (.*);

// File: tb/tb_cpu_boot_sequencer.sv
module tb_cpu_boot_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bsp_strap = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [63:0] base_wr_data = '0;
    logic        init_evt = 1'b0;
    logic        sipi_evt = 1'b0;
    logic [7:0]  sipi_vec = '0;
    logic        sipi_ack = 1'b0;
    logic        tmr_wr_en = 1'b0;
    logic [31:0] tmr_wr_count = '0;
    logic [63:0] now_stamp = '0;
    logic [63:0] base_q;
    logic        halted, sipi_pending, start_pulse;
    logic [15:0] cs_sel;
    logic [31:0] cs_base;
    logic [31:0] tmr_count;
    logic [63:0] tmr_stamp;

    cpu_boot_sequencer dut (.*);

    always #10 clk = ~clk;

    typedef struct {
        logic [15:0] sel;
        logic [31:0] base;
    } start_item_t;

    start_item_t sbq[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: pops expected release items as start pulses appear
    always @(negedge clk) begin
        if (rst_n && start_pulse) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R8", "unexpected start pulse", {48'h0, cs_sel}, 64'h0);
            end else begin
                start_item_t it;
                it = sbq.pop_front();
                check(cs_sel == it.sel, "R7", "cs_sel", {48'h0, cs_sel}, {48'h0, it.sel});
                check(cs_base == it.base, "R7", "cs_base", {32'h0, cs_base}, {32'h0, it.base});
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input bit strap);
        rst_n = 1'b0;
        bsp_strap = strap;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic write_base(input logic [63:0] v);
        base_wr_en = 1'b1; base_wr_data = v; step(); base_wr_en = 1'b0;
    endtask

    task automatic pulse_init();
        init_evt = 1'b1; step(); init_evt = 1'b0;
    endtask

    task automatic send_sipi(input logic [7:0] v);
        sipi_evt = 1'b1; sipi_vec = v; step(); sipi_evt = 1'b0;
    endtask

    task automatic do_ack(input bit expect_start, input logic [7:0] v, input string req);
        if (expect_start) begin
            start_item_t it;
            it.sel  = {v, 8'h00};
            it.base = {12'h000, v, 12'h000};
            sbq.push_back(it);
        end
        sipi_ack = 1'b1; step(); sipi_ack = 1'b0;
        step();
        check(sbq.size() == 0, req, "release item still queued", 64'(sbq.size()), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        // R1: reset state, application processor
        do_reset(1'b0);
        check(base_q == 64'h0000_0000_FEE0_0800, "R1", "base after reset", base_q, 64'hFEE00800);
        check(!halted && !sipi_pending && !start_pulse, "R1", "flags after reset",
              {61'h0, halted, sipi_pending, start_pulse}, 64'h0);
        check(cs_sel == 0 && cs_base == 0 && tmr_count == 0 && tmr_stamp == 0, "R1",
              "values after reset", {cs_base, cs_sel, 16'h0}, 64'h0);

        // R2: address field taken, other bits dropped
        write_base(64'hFFFF_FFFF_1234_5FFF);
        check(base_q == 64'h0000_0000_1234_5800, "R2", "base write", base_q, 64'h12345800);

        // R3: enable clears and stays clear
        write_base(64'h0000_0000_ABCD_E000);
        check(base_q == 64'h0000_0000_ABCD_E000, "R3", "enable cleared", base_q, 64'hABCDE000);
        write_base(64'h0000_0000_FFFF_FFFF);
        check(base_q == 64'h0000_0000_FFFF_F000, "R3", "enable stays clear", base_q, 64'hFFFFF000);

        // R5: timer load, then INIT clears it; R4: application processor halts
        tmr_wr_en = 1'b1; tmr_wr_count = 32'd100; now_stamp = 64'h1234;
        step(); tmr_wr_en = 1'b0;
        check(tmr_count == 32'd100 && tmr_stamp == 64'h1234, "R5", "timer load",
              {tmr_count, tmr_stamp[31:0]}, {32'd100, 32'h1234});
        pulse_init();
        check(tmr_count == 0 && tmr_stamp == 0, "R5", "timer cleared by INIT",
              {tmr_count, tmr_stamp[31:0]}, 64'h0);
        check(halted == 1'b1, "R4", "halted after INIT", {63'h0, halted}, 64'd1);

        // R6 / R7: startup message releases
        send_sipi(8'h9A);
        check(sipi_pending && halted, "R6", "pending while held",
              {62'h0, sipi_pending, halted}, 64'd3);
        do_ack(1'b1, 8'h9A, "R7");
        check(!halted && !sipi_pending, "R7", "released",
              {62'h0, halted, sipi_pending}, 64'd0);

        // R8: second startup without INIT is swallowed
        send_sipi(8'h33);
        do_ack(1'b0, 8'h33, "R8");
        check(!sipi_pending && cs_sel == 16'h9A00 && !halted, "R8", "swallowed startup",
              {47'h0, sipi_pending, cs_sel}, {48'h0, 16'h9A00});

        // R9: acknowledge with nothing pending, while held
        pulse_init();
        do_ack(1'b0, 8'h00, "R9");
        check(halted && !sipi_pending && cs_sel == 16'h9A00, "R9", "idle ack inert",
              {46'h0, halted, sipi_pending, cs_sel}, {46'h0, 2'b10, 16'h9A00});

        // R6: last vector wins, top vector value
        send_sipi(8'h01);
        send_sipi(8'hFF);
        do_ack(1'b1, 8'hFF, "R6");

        // R10: ack together with INIT is ignored
        pulse_init();
        send_sipi(8'h42);
        init_evt = 1'b1; sipi_ack = 1'b1; step(); init_evt = 1'b0; sipi_ack = 1'b0;
        step();
        check(sipi_pending && halted, "R10", "ack ignored with INIT",
              {62'h0, sipi_pending, halted}, 64'd3);
        do_ack(1'b1, 8'h42, "R10");

        // bootstrap processor
        do_reset(1'b1);
        check(base_q == 64'h0000_0000_FEE0_0900, "R1", "base after reset with strap", base_q, 64'hFEE00900);
        write_base(64'h0000_0000_FEE0_0000);
        check(base_q == 64'h0000_0000_FEE0_0100, "R2", "bootstrap flag kept", base_q, 64'hFEE00100);
        pulse_init();
        check(!halted, "R4", "bootstrap not halted", {63'h0, halted}, 64'd0);
        send_sipi(8'h10);
        do_ack(1'b1, 8'h10, "R4");
        send_sipi(8'h20);
        do_ack(1'b0, 8'h20, "R8");
        check(cs_sel == 16'h1000 && cs_base == 32'h0001_0000, "R8", "outputs kept",
              {cs_base, cs_sel, 16'h0}, {32'h00010000, 16'h1000, 16'h0});

        finish_run();
    end
endmodule